// File: doc/BRIEF.md
# Dual-Section Ripple Counter

This block is a four-bit counter made of two independent sections. A single toggle stage forms bit 0 and advances on each falling edge of count input A. A three-bit ripple chain forms bits 1 to 3. Bit 1 advances on each falling edge of count input B, and each higher bit advances when the bit below it falls from one to zero. Two clear inputs are combined so that the whole counter returns to zero only while both are high.

Because the sections are separate, the user chooses the modulus by wiring outputs back to the inputs outside the block. Feeding bit 0 into input B with both clears low gives a divide-by-16 counter. Feeding bit 0 into B and bits 1 and 3 into the two clears gives a decade counter. Two instances can be chained to build larger dividers, for example divide-by-50.

Everything runs on one system clock. Both count inputs pass through a two-flop synchronizer followed by a falling-edge detector. The stages inside the chain detect edges on the registered outputs; no derived clocks are used. A registered clear takes effect on the clock edge after both clear inputs are seen high. A decoded terminal state is therefore visible for one system clock before it returns to zero.

Top module: `ripple_pair_counter`

## Requirements
- R1: While the synchronous reset `rst` is high, `q` is 0000 on the next clock edge, and any edge history is discarded. After reset is released, `q` stays 0000 until a count input falls.
- R2: `q[0]` toggles exactly once for each high-to-low transition of `cnt_a`, on the third system clock edge after `cnt_a` goes low. A rising `cnt_a` leaves `q` unchanged.
- R3: `q[1]` toggles exactly once for each high-to-low transition of `cnt_b`, and `cnt_b` never changes `q[0]`.
- R4: `q[2]` toggles on the clock edge after `q[1]` falls from 1 to 0, and `q[3]` toggles on the clock edge after `q[2]` falls. As a result, bits 3 to 1 count 0 to 7 and wrap.
- R5: When `clr_x` and `clr_y` are both high, `q` is 0000 after the next clock edge, even if count edges arrive at the same time. No bit toggles afterwards because of falls caused by the clear.
- R6: Either clear input high on its own has no effect on `q`.
- R7: With `cnt_b` driven from `q[0]` and both clears low, `q` steps through 0 to 15 and wraps. `q[3]` falls once every 16 falling edges of `cnt_a`.
- R8: With `cnt_b` driven from `q[0]`, `clr_x` from `q[1]` and `clr_y` from `q[3]`, the settled count runs 0 to 9 and then returns to 0. `q[3]` falls once every 10 falling edges of `cnt_a`.
- R9: Chaining a decade-strapped instance's `q[3]` into `cnt_b` of a second instance strapped to divide by five gives a second-instance `q[3]` that falls once every 50 falling edges of the first `cnt_a`. The second instance is strapped with clears from its `q[1]` and `q[3]` and with `cnt_a` tied low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| cnt_a | input | 1 | Count input for bit 0 (asynchronous, falling edge counts) |
| cnt_b | input | 1 | Count input for the bit 1 to 3 chain (asynchronous, falling edge counts) |
| clr_x | input | 1 | First clear input; clears only together with `clr_y` |
| clr_y | input | 1 | Second clear input; clears only together with `clr_x` |
| q | output | 4 | Counter state; bit 0 is the single stage, bits 3 to 1 are the chain |

## Verification
The gated clear and the counting path can act in the same clock. The bench provokes this by holding both clear inputs high while it applies falling edges to both count inputs. It also lets the decade strapping raise the clear in the very cycle a ripple toggle lands. Correct behaviour is judged at the ports: `q` must remain 0000 while the clear is held, and no stage may toggle afterwards because of a fall that the clear itself produced. In the decade and cascade runs, the settled counts and the number of `q[3]` falls must match the expected dividers.

// File: rtl/ripple_pair_counter.sv
module ripple_pair_counter #(
  parameter int SYNC_DEPTH = 2,
  parameter int CHAIN_BITS = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cnt_a,
  input  logic                  cnt_b,
  input  logic                  clr_x,
  input  logic                  clr_y,
  output logic [CHAIN_BITS:0]   q
);

  logic [SYNC_DEPTH-1:0]   a_sync, b_sync;
  logic                    a_last, b_last;
  logic [CHAIN_BITS-1:1]   hist;
  logic [CHAIN_BITS:1]     tick;

  wire a_now     = a_sync[SYNC_DEPTH-1];
  wire b_now     = b_sync[SYNC_DEPTH-1];
  wire a_fall    = a_last & ~a_now;
  wire clear_all = clr_x & clr_y;

  assign tick[1] = b_last & ~b_now;

  for (genvar i = 2; i <= CHAIN_BITS; i++) begin : g_ripple
    assign tick[i] = hist[i-1] & ~q[i-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_sync <= '0;
      b_sync <= '0;
      a_last <= 1'b0;
      b_last <= 1'b0;
      hist   <= '0;
      q      <= '0;
    end else begin
      a_sync <= {a_sync[SYNC_DEPTH-2:0], cnt_a};
      b_sync <= {b_sync[SYNC_DEPTH-2:0], cnt_b};
      a_last <= a_now;
      b_last <= b_now;
      if (clear_all) begin
        q    <= '0;
        hist <= '0;
      end else begin
        q[0] <= q[0] ^ a_fall;
        for (int i = 1; i <= CHAIN_BITS; i++) q[i] <= q[i] ^ tick[i];
        hist <= q[CHAIN_BITS-1:1];
      end
    end
  end

  // R1
  reset_zero_chk: assert property (@(posedge clk) rst |=> q == '0);

  // R2
  a_only_moves_bit0_chk: assert property (@(posedge clk) disable iff (rst)
    (!clear_all && !a_fall) |=> q[0] == $past(q[0]));

  // R4
  ripple_bit2_chk: assert property (@(posedge clk) disable iff (rst)
    (hist[1] && !q[1] && !clear_all) |=> q[2] != $past(q[2]));

  // R4
  ripple_bit3_chk: assert property (@(posedge clk) disable iff (rst)
    (hist[2] && !q[2] && !clear_all) |=> q[3] != $past(q[3]));

  // R5
  gated_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_x && clr_y) |=> q == '0);

endmodule

// File: tb/ripple_pair_counter_tb.sv
`timescale 1ns/1ps
module ripple_pair_counter_tb_top;
  localparam int H = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a_drv = 1'b0, b_drv = 1'b0, cx = 1'b0, cy = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [3:0] q, q2;
  logic b_in, cx_in, cy_in;
  int checks = 0, errors = 0;
  int n_fall1 = 0, n_fall2 = 0;
  logic q3_d = 1'b0, q23_d = 1'b0;

  always #5 clk = ~clk;

  assign b_in  = (mode == 2'd0) ? b_drv : q[0];
  assign cx_in = (mode == 2'd2) ? q[1] : cx;
  assign cy_in = (mode == 2'd2) ? q[3] : cy;

  ripple_pair_counter dut_i (.clk(clk), .rst(rst), .cnt_a(a_drv), .cnt_b(b_in),
                             .clr_x(cx_in), .clr_y(cy_in), .q(q));
  ripple_pair_counter dut_b (.clk(clk), .rst(rst), .cnt_a(1'b0), .cnt_b(q[3]),
                             .clr_x(q2[1]), .clr_y(q2[3]), .q(q2));

  always @(negedge clk) begin
    q3_d  <= q[3];
    q23_d <= q2[3];
    if (q3_d && !q[3])   n_fall1 <= n_fall1 + 1;
    if (q23_d && !q2[3]) n_fall2 <= n_fall2 + 1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    mode = m; a_drv = 0; b_drv = 0; cx = 0; cy = 0; rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_a();
    @(negedge clk) a_drv = 1;
    repeat (H) @(negedge clk);
    a_drv = 0;
    repeat (H + 8) @(negedge clk);
  endtask

  task automatic pulse_b();
    @(negedge clk) b_drv = 1;
    repeat (H) @(negedge clk);
    b_drv = 0;
    repeat (H + 8) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk) rst = 1; a_drv = 1;
    repeat (3) @(negedge clk);
    a_drv = 0;
    repeat (3) @(negedge clk);
    chk("R1 zero during reset", q, 0);
    rst = 0;
    repeat (8) @(negedge clk);
    chk("R1 zero after release", q, 0);
  endtask

  task automatic t_bit0();
    do_reset(2'd0);
    for (int k = 1; k <= 3; k++) begin
      pulse_a();
      chk("R2 bit0 parity", q, k % 2);
    end
    @(negedge clk) a_drv = 1;
    repeat (10) @(negedge clk);
    chk("R2 rising edge ignored", q, 1);
    a_drv = 0;
    repeat (2) @(negedge clk);
    chk("R2 not yet toggled", q, 1);
    @(negedge clk);
    chk("R2 toggled on third edge", q, 0);
  endtask

  task automatic t_chain();
    do_reset(2'd0);
    pulse_a();
    for (int k = 1; k <= 9; k++) begin
      pulse_b();
      chk("R3 R4 chain value", q[3:1], k % 8);
      chk("R3 bit0 untouched", q[0], 1);
    end
  endtask

  task automatic t_clear();
    do_reset(2'd0);
    pulse_a(); pulse_b(); pulse_b(); pulse_b();
    chk("R4 setup value", q, 7);
    @(negedge clk) cx = 1;
    repeat (4) @(negedge clk);
    chk("R6 clr_x alone", q, 7);
    cx = 0; cy = 1;
    repeat (4) @(negedge clk);
    chk("R6 clr_y alone", q, 7);
    cx = 1;
    @(negedge clk);
    chk("R5 clear next edge", q, 0);
    a_drv = 1; b_drv = 1;
    repeat (H) @(negedge clk);
    a_drv = 0; b_drv = 0;
    repeat (H + 6) @(negedge clk);
    chk("R5 clear beats counting", q, 0);
    cx = 0; cy = 0;
    repeat (8) @(negedge clk);
    chk("R5 no ripple after clear", q, 0);
  endtask

  task automatic t_mod16();
    int base;
    do_reset(2'd1);
    base = n_fall1;
    for (int k = 1; k <= 32; k++) begin
      pulse_a();
      if (k <= 18) chk("R7 mod16 value", q, k % 16);
    end
    chk("R7 bit3 falls per 32", n_fall1 - base, 2);
  endtask

  task automatic t_decade();
    int base;
    do_reset(2'd2);
    base = n_fall1;
    for (int k = 1; k <= 25; k++) begin
      pulse_a();
      chk("R8 decade value", q, k % 10);
    end
    chk("R8 bit3 falls per 25", n_fall1 - base, 2);
  endtask

  task automatic t_cascade();
    int b1, b2;
    do_reset(2'd2);
    b1 = n_fall1; b2 = n_fall2;
    for (int k = 1; k <= 100; k++) pulse_a();
    repeat (30) @(negedge clk);
    chk("R9 first stage falls", n_fall1 - b1, 10);
    chk("R9 divide by 50 falls", n_fall2 - b2, 2);
    chk("R9 second stage residue", q2, 0);
  endtask

  initial begin
    t_reset();
    t_bit0();
    t_chain();
    t_clear();
    t_mod16();
    t_decade();
    t_cascade();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule